// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Engine

This engine carries an incoming byte stream into memory buffers. It walks a chain of descriptors held in a word-addressed memory. Each descriptor occupies four consecutive 32-bit words. Word 0 is the parameter word. Word 1 points to the next descriptor. Word 2 points to the data buffer. Word 3 is the status word that the engine writes back. The chain is linked only through the next pointer, so a ring exists when the last descriptor points back to the first.

Once the channel is enabled, the engine starts at the first-descriptor address. For each descriptor it reads three words, then fills the buffer with bytes packed into little-endian words. When the buffer is complete it writes the status word. A descriptor whose parameter word carries the hold flag is not used. The engine waits for a programmable poll interval and then reads that descriptor again. Software uses this flag to keep the engine from overrunning buffers it has not yet emptied.

Top module: `rxd_ring_dma`

## Requirements
- R1: After the engine starts at a descriptor, it reads the parameter word, the next pointer and the buffer pointer. These reads go to word offsets 0, 1 and 2 of the descriptor, in that order. Word address = byte address / 4.
- R2: A parameter word with bit 31 (hold) set stops the engine at that descriptor. It reads no pointer, accepts no byte and writes nothing. It reads the parameter word again every N+3 cycles, where N is the poll interval.
- R3: The poll interval register resets to 7, giving reads every 10 cycles. It takes a new value when `poll_wr` is high.
- R4: Byte k of a descriptor's buffer is written to buffer word k/4, in bits 8*(k mod 4)+7 : 8*(k mod 4). Unused upper bytes of the final partial word are written as zero.
- R5: The status word is written only after the last data write of its descriptor. It holds bit 31 = 1 (complete), bit 30 = start of frame, bit 29 = end of frame and bits 16:0 = the number of bytes stored. That count includes the 4-byte FCS carried in the stream. All other bits are zero.
- R6: When a frame reaches the limit in parameter bits 21:0 before its last byte, the frame continues in the next descriptor. Only the first descriptor of the frame sets the start bit, and only the last sets the end bit.
- R7: After a status write, the engine moves to the descriptor named by the next pointer. When the last descriptor points to the first, the engine wraps around the ring and reuses it.
- R8: Dropping `ch_enable` lets the current descriptor complete. After that the engine makes no memory access and holds `in_ready` low. Raising `ch_enable` again restarts at `ch_start_addr`.
- R9: A start address with bits 3:0 nonzero sets `err_misalign`, and the engine makes no memory access. The flag clears when `ch_enable` goes low.
- R10: After reset, `in_ready`, `mem_en` and `err_misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 1 | Channel on (level) |
| ch_start_addr | input | 32 | Byte address of the first descriptor |
| poll_wr | input | 1 | Load strobe for the poll interval |
| poll_val | input | PW | New poll interval in cycles |
| err_misalign | output | 1 | Start address was not 16-byte aligned |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Engine accepts a byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
Some properties are checked by the assertions on every cycle. A held descriptor leaves the memory port idle in the following cycle. The poll counter decreases by one per waiting cycle. A status write always follows a data write directly. No byte is taken at or past the buffer limit. No access happens while the error flag is up. A stalled `in_ready` stays high. Other behaviour can only be shown by the bench scenarios: the packed buffer contents and status values, a frame split across descriptors, the ring wrap, the exact re-read spacing at both poll settings, stopping and restarting at a new start address, and the misaligned start.

// File: rtl/rxd_pkg.sv
// Shared definitions for the descriptor ring receive engine.
// Assumes 32-bit descriptor words and byte-granular stream input.
package rxd_pkg;
    localparam int HOLD_BIT = 31;
    localparam int LIM_W    = 22;
    localparam int CNT_W    = 17;
    localparam int ST_DONE  = 31;
    localparam int ST_SOP   = 30;
    localparam int ST_EOP   = 29;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RDP, ST_CHKP, ST_GETN, ST_GETB, ST_DATA, ST_STAT, ST_POLL
    } rxd_state_e;

    // Builds the write-back status word from its fields.
    function automatic logic [31:0] make_status(logic sop, logic eop, logic [CNT_W-1:0] cnt);
        logic [31:0] s;
        s = '0;
        s[ST_DONE] = 1'b1;
        s[ST_SOP]  = sop;
        s[ST_EOP]  = eop;
        s[CNT_W-1:0] = cnt;
        return s;
    endfunction
endpackage

// File: rtl/rxd_poll_timer.sv
// Holds the programmable poll interval and counts down a wait period.
// Assumes load and run never conflict in a way that matters: load wins.
module rxd_poll_timer #(
    parameter int PW      = 8,
    parameter int DEFAULT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [PW-1:0] cfg_val,
    input  logic          load,
    input  logic          run,
    output logic          expired
);
    logic [PW-1:0] ivl;
    logic [PW-1:0] cnt;

    // Interval register, reset to its default.
    always_ff @(posedge clk) begin
        if (!rst_n)      ivl <= PW'(DEFAULT);
        else if (cfg_wr) ivl <= cfg_val;
    end

    // Countdown: loaded on a held descriptor, decremented while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= ivl;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    a_r2_poll_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    a_r3_load_takes_interval: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(ivl)));
endmodule

// File: rtl/rxd_packer.sv
// Packs stream bytes little-endian into 32-bit words and counts them.
// Signals a word flush on a full word, the frame end or the buffer limit.
// Assumes a nonzero limit that fits the count width.
module rxd_packer
    import rxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       din,
    input  logic             last,
    input  logic [LIM_W-1:0] lim,
    output logic [31:0]      wr_word,
    output logic             flush,
    output logic             done,
    output logic [CNT_W-3:0] word_idx,
    output logic [CNT_W-1:0] count
);
    logic [31:0]      acc;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic [1:0]       lane;
    logic             at_lim;

    // Lane selection and end-of-buffer detection for the byte in flight.
    always_comb begin
        lane     = cnt[1:0];
        cnt_next = cnt + 1'b1;
        at_lim   = (LIM_W'(cnt_next) == lim);
        wr_word  = acc | (32'(din) << {lane, 3'b000});
        flush    = take && (lane == 2'd3 || last || at_lim);
        done     = take && (last || at_lim);
    end

    // Accumulator and byte counter, cleared at each new descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt_next;
            acc <= flush ? 32'h0 : wr_word;
        end
    end

    assign word_idx = cnt[CNT_W-1:2];
    assign count    = cnt;

    a_r6_take_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (LIM_W'(cnt) < lim));
    a_r4_fresh_word_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cnt[1:0] == 2'd0) |-> (acc == 32'h0));
endmodule

// File: rtl/rxd_ring_dma.sv
// Receive engine walking a ring of four-word descriptors in word memory.
// Fetches parameter, next and buffer words, stores stream bytes, writes
// status, follows the next pointer. Held descriptors are re-polled.
// Assumes memory read data arrives one cycle after a read request and
// buffer pointers are word aligned.
module rxd_ring_dma
    import rxd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int PW       = 8,
    parameter int POLL_DEF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_enable,
    input  logic [31:0]   ch_start_addr,
    input  logic          poll_wr,
    input  logic [PW-1:0] poll_val,
    output logic          err_misalign,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    rxd_state_e       state;
    logic [AW-1:0]    cur_w, nxt_w, buf_w;
    logic [LIM_W-1:0] lim;
    logic             cont, eop_q;
    logic             take, pk_flush, pk_done, tmr_exp;
    logic [31:0]      pk_word;
    logic [CNT_W-3:0] pk_idx;
    logic [CNT_W-1:0] pk_count;
    logic             unused_bits;

    assign unused_bits = ^{ch_start_addr[31:AW+2], mem_rdata[30:LIM_W],
                           mem_rdata[1:0]};
    assign take     = (state == ST_DATA) && in_valid;
    assign in_ready = (state == ST_DATA);

    rxd_poll_timer #(.PW(PW), .DEFAULT(POLL_DEF)) u_timer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(poll_wr), .cfg_val(poll_val),
        .load(state == ST_CHKP && mem_rdata[HOLD_BIT]),
        .run(state == ST_POLL), .expired(tmr_exp));

    rxd_packer u_pack (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_GETB), .take(take),
        .din(in_data), .last(in_last), .lim(lim), .wr_word(pk_word),
        .flush(pk_flush), .done(pk_done), .word_idx(pk_idx), .count(pk_count));

    // Main sequencer: start, descriptor fetch, fill, write-back, poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_w <= '0; nxt_w <= '0; buf_w <= '0; lim <= '0;
            cont <= 1'b0; eop_q <= 1'b0; err_misalign <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!ch_enable) err_misalign <= 1'b0;
                    else if (!err_misalign) begin
                        if (ch_start_addr[3:0] == 4'h0) begin
                            cur_w <= ch_start_addr[AW+1:2];
                            cont  <= 1'b0;
                            state <= ST_RDP;
                        end else begin
                            err_misalign <= 1'b1;
                        end
                    end
                end
                ST_RDP:  state <= ch_enable ? ST_CHKP : ST_IDLE;
                ST_CHKP: begin
                    if (mem_rdata[HOLD_BIT]) state <= ST_POLL;
                    else begin
                        lim   <= mem_rdata[LIM_W-1:0];
                        state <= ST_GETN;
                    end
                end
                ST_GETN: begin
                    nxt_w <= mem_rdata[AW+1:2];
                    state <= ST_GETB;
                end
                ST_GETB: begin
                    buf_w <= mem_rdata[AW+1:2];
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (pk_done) begin
                        eop_q <= in_last;
                        state <= ST_STAT;
                    end
                end
                ST_STAT: begin
                    cur_w <= nxt_w;
                    cont  <= !eop_q;
                    state <= ST_RDP;
                end
                ST_POLL: if (tmr_exp) state <= ST_RDP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port: one access per cycle chosen by the sequencer state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_w;
        mem_wdata = '0;
        case (state)
            ST_RDP:  mem_en = ch_enable;
            ST_CHKP: begin
                mem_en   = !mem_rdata[HOLD_BIT];
                mem_addr = cur_w + AW'(1);
            end
            ST_GETN: begin
                mem_en   = 1'b1;
                mem_addr = cur_w + AW'(2);
            end
            ST_DATA: begin
                mem_en    = pk_flush;
                mem_we    = pk_flush;
                mem_addr  = buf_w + AW'(pk_idx);
                mem_wdata = pk_word;
            end
            ST_STAT: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_w + AW'(3);
                mem_wdata = make_status(!cont, eop_q, pk_count);
            end
            default: ;
        endcase
    end

    a_r2_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHKP && mem_rdata[HOLD_BIT]) |=> (state == ST_POLL && !mem_en));
    a_r5_status_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAT) |-> $past(mem_en && mem_we));
    a_r9_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_misalign |-> (!mem_en && !in_ready));
    a_r8_stop_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_RDP) |-> !$past(ch_enable));
    a_r4_ready_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);
endmodule

// File: tb/rxd_ring_dma_bench.sv
module rxd_ring_dma_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0, ch_enable = 1'b0, poll_wr = 1'b0;
    logic [31:0] ch_start_addr = '0;
    logic [7:0]  poll_val = '0;
    logic err_misalign, in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0] in_data = '0;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    logic hw_en = 1'b0;
    logic [7:0] hw_addr = '0;
    logic [31:0] hw_data = '0;
    logic [31:0] mem [0:255];

    int checks = 0, errors = 0, cyc = 0, acc_cnt = 0;
    int last_t = 0, prev_t = 0;
    bit finished = 1'b0;
    logic [AW-1:0] q_addr[$];
    logic [31:0]   q_data[$];
    logic [AW-1:0] rd_log[$];

    rxd_ring_dma u_rxd_ring_dma (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_start_addr(ch_start_addr),
        .poll_wr(poll_wr), .poll_val(poll_val), .err_misalign(err_misalign),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata));

    // Memory model: one-cycle read latency, plus a host write port.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (hw_en) mem[hw_addr] <= hw_data;
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes, logs reads, samples after settling.
    initial forever begin
        @(negedge clk); #2;
        if (mem_en) acc_cnt++;
        if (mem_en && !mem_we) begin
            rd_log.push_back(mem_addr);
            if (mem_addr == AW'(20)) begin prev_t = last_t; last_t = cyc; end
        end
        if (mem_en && mem_we) begin
            if (q_addr.size() == 0) check(1'b0, "R5 unexpected write", 32'(mem_addr), 32'hFFFF);
            else begin
                logic [AW-1:0] ea;
                logic [31:0] ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                check(mem_addr == ea, "R7 write address", 32'(mem_addr), 32'(ea));
                check(mem_wdata == ed, "R4 R5 R6 write data", mem_wdata, ed);
            end
        end
    end

    task automatic hwrite(input int a, input logic [31:0] d);
        @(negedge clk); hw_en = 1'b1; hw_addr = 8'(a); hw_data = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    // Driver side of the scoreboard: expected buffer words then status.
    task automatic expect_desc(input int dw, input int bw, input int seed, input int first,
                               input int n, input bit sop, input bit eop);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < n; k++) begin
            w[8*(k%4) +: 8] = 8'(seed + first + k);
            if (k % 4 == 3 || k == n - 1) begin
                q_addr.push_back(AW'(bw + k/4));
                q_data.push_back(w);
                w = '0;
            end
        end
        q_addr.push_back(AW'(dw + 3));
        q_data.push_back({1'b1, sop, eop, 12'h000, 17'(n)});
    endtask

    task automatic send_frame(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = 8'(seed + i); in_last = (i == n - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain();
        while (q_addr.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a0;
        // Ring: D0 @0x40, D1 @0x50, D2 @0x60 (limit 8), D2 -> D0.
        hwrite(16, 32'd64);  hwrite(17, 32'h50); hwrite(18, 32'h100); hwrite(19, 0);
        hwrite(20, 32'd64);  hwrite(21, 32'h60); hwrite(22, 32'h200); hwrite(23, 0);
        hwrite(24, 32'd8);   hwrite(25, 32'h40); hwrite(26, 32'h300); hwrite(27, 0);
        @(negedge clk); rst_n = 1'b1; #2;
        check(!in_ready && !mem_en && !err_misalign, "R10 reset outputs",
              {29'd0, in_ready, mem_en, err_misalign}, 32'd0);

        ch_start_addr = 32'h40; ch_enable = 1'b1;
        rd_log.delete();
        expect_desc(16, 64, 8'h10, 0, 10, 1, 1);   // R1 R4 R5: 10 bytes incl FCS
        send_frame(8'h10, 10); drain();
        check(rd_log[0] == 16 && rd_log[1] == 17 && rd_log[2] == 18, "R1 fetch order",
              32'(rd_log[1]), 32'd17);
        expect_desc(20, 128, 8'h30, 0, 9, 1, 1);   // R7 next descriptor
        send_frame(8'h30, 9); drain();

        hwrite(20, 32'h8000_0040);                   // R2 hold on D1
        expect_desc(24, 192, 8'h50, 0, 8, 1, 0);     // R6 spans D2 then wraps
        expect_desc(16, 64, 8'h50, 8, 5, 0, 1);      // R7 wrap to D0
        send_frame(8'h50, 13); drain();

        repeat (40) @(negedge clk); #2;
        check(last_t - prev_t == 10, "R3 default poll spacing", 32'(last_t - prev_t), 32'd10);
        check(!in_ready, "R2 held descriptor takes no data", 32'(in_ready), 32'd0);
        @(negedge clk); poll_wr = 1'b1; poll_val = 8'd2;
        @(negedge clk); poll_wr = 1'b0;
        repeat (30) @(negedge clk); #2;
        check(last_t - prev_t == 5, "R2 R3 reprogrammed poll spacing", 32'(last_t - prev_t), 32'd5);

        hwrite(20, 32'd64);
        expect_desc(20, 128, 8'h70, 0, 6, 1, 1);
        send_frame(8'h70, 6); drain();

        repeat (5) @(negedge clk);
        ch_enable = 1'b0;                             // R8 finish D2 then stop
        expect_desc(24, 192, 8'h90, 0, 3, 1, 1);
        send_frame(8'h90, 3); drain();
        a0 = acc_cnt;
        repeat (20) @(negedge clk); #2;
        check(acc_cnt == a0, "R8 no access after stop", 32'(acc_cnt), 32'(a0));
        check(!in_ready, "R8 ready low after stop", 32'(in_ready), 32'd0);

        ch_start_addr = 32'h50; rd_log.delete();
        @(negedge clk); ch_enable = 1'b1;            // R8 restart at start register
        expect_desc(20, 128, 8'hA0, 0, 4, 1, 1);
        send_frame(8'hA0, 4); drain();
        check(rd_log[0] == 20, "R8 restart address", 32'(rd_log[0]), 32'd20);

        ch_enable = 1'b0;
        expect_desc(24, 192, 8'hB0, 0, 2, 1, 1);
        send_frame(8'hB0, 2); drain();
        repeat (3) @(negedge clk);

        ch_start_addr = 32'h44; ch_enable = 1'b1;    // R9 misaligned start
        repeat (3) @(negedge clk); #2;
        check(err_misalign, "R9 error flag set", 32'(err_misalign), 32'd1);
        a0 = acc_cnt;
        repeat (10) @(negedge clk); #2;
        check(acc_cnt == a0 && !in_ready, "R9 channel stays off", 32'(acc_cnt), 32'(a0));
        ch_enable = 1'b0;
        repeat (2) @(negedge clk); #2;
        check(!err_misalign, "R9 flag clears when disabled", 32'(err_misalign), 32'd0);
        check(q_addr.size() == 0, "R5 all expected writes seen", 32'(q_addr.size()), 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule